// File: doc/BRIEF.md
# Hamming-Coded Parallel Lane Corrector

This block guards four parallel linear processing lanes (filters, transforms or any operation where the response to a sum equals the sum of the responses) with three extra redundant lanes. The four original lanes act as the data positions of a (7,4) Hamming code, and the three redundant lanes act as its check positions. Parity is formed by arithmetic addition rather than by XOR.

On the input side, the block forms the stimulus for each redundant lane as a sum of three original lane inputs. On the output side, it takes one sample from each of the seven lanes per valid cycle. For each check it subtracts the matching sum of original outputs from the redundant output. A check fails only when that difference exceeds a quantization tolerance in either direction. The three check results form a syndrome. A pattern with two or three set bits names the original lane in error, and that lane's sample is rebuilt from a covering redundant output minus the other two covered lanes. A single set bit blames a redundant lane, and the original samples pass through untouched.

The linear lanes sit outside the block. The system feeds the redundant-lane stimulus into its three spare lanes and returns all seven lane outputs, together with a valid strobe. The corrected samples and the fault flags appear one clock later.

Top module: `lane_ecc_guard`

## Requirements
- R1: The redundant stimulus `red_x` is a set of sign-extended sums of original lane inputs, each W+2 bits wide. Slice 0 is lane1+lane2+lane3, slice 1 is lane1+lane2+lane4, and slice 2 is lane1+lane3+lane4. Lane n occupies bits [(n-1)*W +: W] of the flat buses.
- R2: Check k compares redundant output slice k with the sum of its three covered original outputs. It fails when the signed difference is greater than TOL or less than -TOL. A difference of exactly ±TOL passes. The syndrome places check 0 at bit 2, check 1 at bit 1 and check 2 at bit 0.
- R3: Each two- or three-bit syndrome names one original lane, and the one-hot `fix_lane` marks that lane with bit n-1 for lane n. The mapping is: 3'b111 is lane 1, 3'b110 is lane 2, 3'b101 is lane 3, and 3'b011 is lane 4.
- R4: The named lane is replaced by a rebuilt sample, truncated to W bits. The rebuild formulas are:
  - lane 1 = red0 − z2 − z3
  - lane 2 = red0 − z1 − z3
  - lane 3 = red0 − z1 − z2
  - lane 4 = red1 − z1 − z2
- R5: A syndrome with exactly one set bit raises `red_fault`, leaves `fix_lane` at zero, and passes all original samples through unchanged.
- R6: A zero syndrome passes all samples through unchanged with every flag low. `err_flag` is high exactly when the registered syndrome is nonzero.
- R7: Outputs are registered. A sample presented with `z_vld` high appears with `out_vld` high one clock later. When `z_vld` is low, `out_vld` drops in the next cycle and the output samples and flags hold their values.
- R8: While `rst_n` is low, every output register clears to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| x_in | input | 4*W | Original lane inputs, lane n at [(n-1)*W +: W], signed |
| red_x | output | 3*(W+2) | Stimulus for the three redundant lanes, signed |
| z_vld | input | 1 | Lane outputs on z_data and z_red are valid |
| z_data | input | 4*W | Original lane outputs, signed |
| z_red | input | 3*(W+2) | Redundant lane outputs, signed |
| out_vld | output | 1 | Corrected sample valid |
| out_data | output | 4*W | Corrected original lane samples |
| syndrome | output | 3 | Registered check result pattern |
| fix_lane | output | 4 | One-hot original lane that was rebuilt |
| red_fault | output | 1 | A redundant lane was found faulty |
| err_flag | output | 1 | Any check failed |

## Verification
The bench goes after these corner cases:
- **Tolerance edge.** An error of exactly ±TOL must pass unseen, while ±(TOL+1) must trigger correction. A comparator using `>=` or a one-sided compare would flag or miss these samples.
- **Per-lane faults.** Each original lane is corrupted in turn. A wrong subset or syndrome map would rebuild the wrong lane or subtract the wrong neighbours, leaving a corrupt sample at the output.
- **Redundant-lane faults.** A fault in a redundant lane must not touch any data. A design that decoded single-bit syndromes as data errors would corrupt good samples.
- **Extremes and idle cycles.** Extreme negative and positive inputs exercise sign extension in the sums. Idle cycles confirm that the outputs hold and that the valid strobe drops.

// File: rtl/lane_ecc_pkg.sv
// Shared code layout for the lane corrector.
// Assumes four original lanes and three checks in a (7,4) arrangement.
package lane_ecc_pkg;

    localparam int unsigned NLANE = 4;
    localparam int unsigned NCHK  = 3;

    // Returns 1 when check k covers original lane l (both zero-based).
    function automatic logic covers(input int k, input int l);
        logic [NLANE-1:0] m;
        case (k)
            0:       m = 4'b0111;
            1:       m = 4'b1011;
            default: m = 4'b1101;
        endcase
        return m[l];
    endfunction

    // Lowest-numbered check that covers lane l; used for the rebuild.
    function automatic int first_check(input int l);
        int r;
        r = 0;
        for (int k = NCHK - 1; k >= 0; k--) begin
            if (covers(k, l)) r = k;
        end
        return r;
    endfunction

    // Syndrome pattern produced by a fault in lane l (check 0 at MSB).
    function automatic logic [NCHK-1:0] lane_pattern(input int l);
        logic [NCHK-1:0] p;
        for (int k = 0; k < NCHK; k++) p[NCHK-1-k] = covers(k, l);
        return p;
    endfunction

endpackage

// File: rtl/lane_ecc_encoder.sv
// Builds the stimulus for each redundant lane as the signed sum of the
// original lane inputs it covers. Purely combinational.
// Assumes RW >= W+2 so a three-term sum cannot overflow.
module lane_ecc_encoder
    import lane_ecc_pkg::*;
#(
    parameter int unsigned W  = 16,
    parameter int unsigned RW = W + 2
) (
    input  logic [NLANE*W-1:0] x_in,
    output logic [NCHK*RW-1:0] red_x
);

    for (genvar k = 0; k < NCHK; k++) begin : g_chk
        logic [RW-1:0] acc;

        // Sum the sign-extended covered inputs for check k.
        always_comb begin
            acc = '0;
            for (int l = 0; l < NLANE; l++) begin
                if (covers(k, l)) begin
                    acc = acc + {{(RW-W){x_in[l*W+W-1]}}, x_in[l*W +: W]};
                end
            end
        end

        assign red_x[k*RW +: RW] = acc;
    end

endmodule

// File: rtl/lane_ecc_check.sv
// One arithmetic parity check: redundant output minus the covered original
// outputs, failing when the difference leaves the band [-TOL, +TOL].
// Assumes DW >= RW+2 so the difference is exact.
module lane_ecc_check
    import lane_ecc_pkg::*;
#(
    parameter int unsigned W   = 16,
    parameter int unsigned RW  = W + 2,
    parameter int unsigned DW  = W + 4,
    parameter int unsigned TOL = 2,
    parameter int unsigned K   = 0
) (
    input  logic [NLANE*W-1:0] z_data,
    input  logic [RW-1:0]      z_red_k,
    output logic               fail
);

    localparam logic signed [DW-1:0] TOLS = $signed(DW'(TOL));

    logic [DW-1:0]        acc;
    logic signed [DW-1:0] diff;

    // Residue of the check: redundant sample minus covered originals.
    always_comb begin
        acc = {{(DW-RW){z_red_k[RW-1]}}, z_red_k};
        for (int l = 0; l < NLANE; l++) begin
            if (covers(K, l)) begin
                acc = acc - {{(DW-W){z_data[l*W+W-1]}}, z_data[l*W +: W]};
            end
        end
        diff = $signed(acc);
    end

    // Two-sided tolerance compare; the edge value itself passes.
    assign fail = (diff > TOLS) || (diff < -TOLS);

endmodule

// File: rtl/lane_ecc_fix.sv
// Decodes the syndrome and rebuilds the named original lane by subtraction
// from the first check that covers it. Single-bit syndromes only report a
// redundant-lane fault. Assumes DW >= RW+2.
module lane_ecc_fix
    import lane_ecc_pkg::*;
#(
    parameter int unsigned W  = 16,
    parameter int unsigned RW = W + 2,
    parameter int unsigned DW = W + 4
) (
    input  logic [NCHK-1:0]    syn,
    input  logic [NLANE*W-1:0] z_data,
    input  logic [NCHK*RW-1:0] z_red,
    output logic [NLANE*W-1:0] fixed,
    output logic [NLANE-1:0]   fix_lane,
    output logic               red_fault
);

    for (genvar l = 0; l < NLANE; l++) begin : g_lane
        localparam int              FK  = first_check(l);
        localparam logic [NCHK-1:0] PAT = lane_pattern(l);

        logic [DW-1:0] rebuilt;
        logic          hit;

        // Rebuild lane l as covering redundant sample minus the other covered lanes.
        always_comb begin
            rebuilt = {{(DW-RW){z_red[FK*RW+RW-1]}}, z_red[FK*RW +: RW]};
            for (int j = 0; j < NLANE; j++) begin
                if (j != l && covers(FK, j)) begin
                    rebuilt = rebuilt - {{(DW-W){z_data[j*W+W-1]}}, z_data[j*W +: W]};
                end
            end
        end

        assign hit                = (syn == PAT);
        assign fix_lane[l]        = hit;
        assign fixed[l*W +: W]    = hit ? rebuilt[W-1:0] : z_data[l*W +: W];
    end

    assign red_fault = $onehot(syn);

endmodule

// File: rtl/lane_ecc_guard.sv
// Top of the lane corrector: encoder for the redundant stimulus, three
// tolerance checks, syndrome decode and rebuild, and a one-cycle output
// register. Assumes at most one faulty lane per sample.
module lane_ecc_guard
    import lane_ecc_pkg::*;
#(
    parameter int unsigned W   = 16,
    parameter int unsigned TOL = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [4*W-1:0]         x_in,
    output logic [3*(W+2)-1:0]     red_x,
    input  logic                   z_vld,
    input  logic [4*W-1:0]         z_data,
    input  logic [3*(W+2)-1:0]     z_red,
    output logic                   out_vld,
    output logic [4*W-1:0]         out_data,
    output logic [2:0]             syndrome,
    output logic [3:0]             fix_lane,
    output logic                   red_fault,
    output logic                   err_flag
);

    localparam int unsigned RW = W + 2;
    localparam int unsigned DW = W + 4;

    logic [NCHK-1:0]    syn_c;
    logic [NLANE*W-1:0] fixed_c;
    logic [NLANE-1:0]   fix_c;
    logic               redf_c;

    lane_ecc_encoder #(.W(W), .RW(RW)) u_enc (
        .x_in  (x_in),
        .red_x (red_x)
    );

    for (genvar k = 0; k < NCHK; k++) begin : g_chk
        lane_ecc_check #(.W(W), .RW(RW), .DW(DW), .TOL(TOL), .K(k)) u_chk (
            .z_data  (z_data),
            .z_red_k (z_red[k*RW +: RW]),
            .fail    (syn_c[NCHK-1-k])
        );
    end

    lane_ecc_fix #(.W(W), .RW(RW), .DW(DW)) u_fix (
        .syn       (syn_c),
        .z_data    (z_data),
        .z_red     (z_red),
        .fixed     (fixed_c),
        .fix_lane  (fix_c),
        .red_fault (redf_c)
    );

    // Valid strobe follows the input strobe by one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) out_vld <= 1'b0;
        else        out_vld <= z_vld;
    end

    // Capture corrected samples and flags on each valid input sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_data  <= '0;
            syndrome  <= '0;
            fix_lane  <= '0;
            red_fault <= 1'b0;
            err_flag  <= 1'b0;
        end else if (z_vld) begin
            out_data  <= fixed_c;
            syndrome  <= syn_c;
            fix_lane  <= fix_c;
            red_fault <= redf_c;
            err_flag  <= |syn_c;
        end
    end

endmodule

// File: rtl/lane_ecc_guard_sva.sv
// Property checker for lane_ecc_guard, attached by bind.
// Assumes reset is asserted at the start of simulation.
module lane_ecc_guard_sva #(
    parameter int unsigned W = 16
) (
    input logic           clk,
    input logic           rst_n,
    input logic           z_vld,
    input logic [4*W-1:0] z_data,
    input logic           out_vld,
    input logic [4*W-1:0] out_data,
    input logic [2:0]     syndrome,
    input logic [3:0]     fix_lane,
    input logic           red_fault,
    input logic           err_flag
);

    assert_vld_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
        z_vld |=> out_vld);

    assert_vld_drops_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !z_vld |=> !out_vld && $stable(out_data) && $stable(syndrome));

    assert_fix_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(fix_lane));

    assert_fix_sets_err_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (fix_lane != 4'd0 || red_fault) |-> err_flag);

    assert_red_no_fix_R5: assert property (@(posedge clk) disable iff (!rst_n)
        red_fault |-> (fix_lane == 4'd0));

    assert_red_pass_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_vld && red_fault) |-> (out_data == $past(z_data)));

    assert_clean_pass_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_vld && syndrome == 3'd0) |-> (out_data == $past(z_data) && !err_flag));

endmodule

bind lane_ecc_guard lane_ecc_guard_sva #(.W(W)) u_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .z_vld     (z_vld),
    .z_data    (z_data),
    .out_vld   (out_vld),
    .out_data  (out_data),
    .syndrome  (syndrome),
    .fix_lane  (fix_lane),
    .red_fault (red_fault),
    .err_flag  (err_flag)
);

// File: tb/tb_lane_ecc_guard.sv
// Bench for lane_ecc_guard: lanes modelled as gain-of-two stages, with one
// fault injected per sample, directed corners plus seeded random cases.
module tb_lane_ecc_guard;

    localparam int W   = 16;
    localparam int RW  = W + 2;
    localparam int TOL = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [4*W-1:0]    x_in = '0;
    logic [3*RW-1:0]   red_x;
    logic              z_vld = 1'b0;
    logic [4*W-1:0]    z_data = '0;
    logic [3*RW-1:0]   z_red = '0;
    logic              out_vld;
    logic [4*W-1:0]    out_data;
    logic [2:0]        syndrome;
    logic [3:0]        fix_lane;
    logic              red_fault;
    logic              err_flag;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    lane_ecc_guard #(.W(W), .TOL(TOL)) dut (
        .clk(clk), .rst_n(rst_n), .x_in(x_in), .red_x(red_x),
        .z_vld(z_vld), .z_data(z_data), .z_red(z_red),
        .out_vld(out_vld), .out_data(out_data), .syndrome(syndrome),
        .fix_lane(fix_lane), .red_fault(red_fault), .err_flag(err_flag)
    );

    always #4 clk = ~clk;

    // Lane coverage of each check, per R1/R2.
    function automatic bit cov(input int k, input int l);
        case (k)
            0:       return (l == 0 || l == 1 || l == 2);
            1:       return (l == 0 || l == 1 || l == 3);
            default: return (l == 0 || l == 2 || l == 3);
        endcase
    endfunction

    // Truncate to a signed W-bit value.
    function automatic int trunc_w(input int v);
        logic [W-1:0] t;
        t = v[W-1:0];
        return int'($signed(t));
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One sample: x inputs, fault target (0 none, 1-4 original, 5-7 redundant), error.
    task automatic run_case(input int x0, input int x1, input int x2, input int x3,
                            input int flane, input int e);
        int xs[4];
        int zt[4];
        int zr[3];
        int d;
        int s[3];
        int syn;
        int expd[4];
        int expfix;
        bit expred;
        xs[0] = x0; xs[1] = x1; xs[2] = x2; xs[3] = x3;
        for (int l = 0; l < 4; l++) x_in[l*W +: W] = W'(xs[l]);
        #1;
        for (int k = 0; k < 3; k++) begin
            int sum = 0;
            for (int l = 0; l < 4; l++) if (cov(k, l)) sum += xs[l];
            check(int'($signed(red_x[k*RW +: RW])) == sum, "R1 red_x sum",
                  int'($signed(red_x[k*RW +: RW])), sum);
            zr[k] = 2 * sum;
        end
        for (int l = 0; l < 4; l++) zt[l] = 2 * xs[l];
        if (flane >= 1 && flane <= 4) zt[flane-1] += e;
        if (flane >= 5) zr[flane-5] += e;
        for (int k = 0; k < 3; k++) begin
            d = zr[k];
            for (int l = 0; l < 4; l++) if (cov(k, l)) d -= zt[l];
            s[k] = (d > TOL || d < -TOL) ? 1 : 0;
        end
        syn = s[0] * 4 + s[1] * 2 + s[2];
        for (int l = 0; l < 4; l++) expd[l] = zt[l];
        expfix = 0;
        case (syn)
            7: begin expfix = 1; expd[0] = trunc_w(zr[0] - zt[1] - zt[2]); end
            6: begin expfix = 2; expd[1] = trunc_w(zr[0] - zt[0] - zt[2]); end
            5: begin expfix = 4; expd[2] = trunc_w(zr[0] - zt[0] - zt[1]); end
            3: begin expfix = 8; expd[3] = trunc_w(zr[1] - zt[0] - zt[1]); end
            default: ;
        endcase
        expred = (syn == 1 || syn == 2 || syn == 4);
        for (int l = 0; l < 4; l++) z_data[l*W +: W] = W'(zt[l]);
        for (int k = 0; k < 3; k++) z_red[k*RW +: RW] = RW'(zr[k]);
        z_vld = 1'b1;
        @(negedge clk);
        z_vld = 1'b0;
        check(out_vld == 1'b1, "R7 out_vld one cycle later", int'(out_vld), 1);
        check(int'(syndrome) == syn, "R2 syndrome", int'(syndrome), syn);
        check(int'(fix_lane) == expfix, "R3 fix_lane", int'(fix_lane), expfix);
        check(red_fault == expred, "R5 red_fault", int'(red_fault), int'(expred));
        check(err_flag == (syn != 0), "R6 err_flag", int'(err_flag), int'(syn != 0));
        for (int l = 0; l < 4; l++) begin
            check(int'($signed(out_data[l*W +: W])) == expd[l], "R4 out_data lane",
                  int'($signed(out_data[l*W +: W])), expd[l]);
        end
        // Idle cycle: inputs change but outputs must hold.
        z_data = ~z_data;
        z_red = ~z_red;
        @(negedge clk);
        check(out_vld == 1'b0, "R7 out_vld drops", int'(out_vld), 0);
        check(int'($signed(out_data[W-1:0])) == expd[0], "R7 hold lane1",
              int'($signed(out_data[W-1:0])), expd[0]);
        check(int'(fix_lane) == expfix, "R7 hold fix_lane", int'(fix_lane), expfix);
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog R7 actual=timeout expected=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        z_vld = 1'b1;
        z_data = '1;
        @(negedge clk);
        @(negedge clk);
        check(out_vld == 1'b0 && out_data == '0, "R8 reset out", int'(out_vld), 0);
        check(syndrome == 3'd0 && fix_lane == 4'd0 && !red_fault && !err_flag,
              "R8 reset flags", int'(syndrome), 0);
        z_vld = 1'b0;
        z_data = '0;
        rst_n = 1'b1;
        @(negedge clk);

        // R6 clean sample, R2 tolerance edge passes, R2 just beyond fails.
        run_case(100, -200, 300, -400, 0, 0);
        run_case(10, 20, 30, 40, 1, TOL);
        run_case(10, 20, 30, 40, 1, -TOL);
        run_case(10, 20, 30, 40, 1, TOL + 1);
        run_case(10, 20, 30, 40, 4, -(TOL + 1));
        // R3/R4 each original lane.
        for (int l = 1; l <= 4; l++) run_case(-4096, 4095, -1, 7, l, 500);
        // R5 each redundant lane.
        for (int r = 5; r <= 7; r++) run_case(4095, 4095, 4095, 4095, r, -700);
        run_case(-4096, -4096, -4096, -4096, 2, 900);

        for (int i = 0; i < 300; i++) begin
            int xs[4];
            int fl;
            int mag;
            int e;
            for (int l = 0; l < 4; l++) xs[l] = int'($urandom_range(8191)) - 4096;
            fl = int'($urandom_range(7));
            mag = ($urandom_range(3) == 0) ? int'($urandom_range(TOL + 1))
                                          : int'($urandom_range(600, 1));
            e = ($urandom_range(1) == 0) ? mag : -mag;
            run_case(xs[0], xs[1], xs[2], xs[3], fl, e);
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule